// File: doc/BRIEF.md
# Serial Front-End Link Deframer

This block sits behind the capture logic of one serial data link coming from a front-end digitizer chip. The link runs at twice the capture clock rate, so the capture flops deliver two bits per clock cycle. No frame or word clock travels with the data, so the block recovers the bit phase from the stream itself. It hunts for the transmitter's fixed 50-bit synchronization packet at every bit offset of a sliding window. The first match fixes the alignment for good, and lock is declared.

Once locked, the block cuts the aligned stream into packets. Each packet opens with a 50-bit header that carries a channel number, a 10-bit payload word count and a tag. The payload words follow. Headers that equal the sync pattern, and headers whose count is zero, are dropped without output. Every payload word of a real data packet is presented as a 10-bit word with a valid strobe and first/last markers. The header fields of that packet are held on their outputs while its words come out.

Top module: `link_deframer`

## Requirements
- R1: A synchronous active-low reset clears the lock, the bit window, the packet parser and the word outputs. While `rst_n` is low, `locked_o` and `word_vld_o` read 0 after the next clock edge.
- R2: While `locked_o` is 0, `word_vld_o` stays 0 whatever bits arrive, including bits laid out like a data packet.
- R3: `pair_i[1]` is the earlier bit of each pair. The block locks on the first occurrence of the `SYNC_WORD` pattern (sent MSB first) at any bit offset, even or odd. `locked_o` rises on the second clock edge after the edge that captured the pair completing the pattern. The packet boundary lies at the bit right after the pattern.
- R4: The alignment is set only once after reset. A later copy of the sync pattern at any bit offset, including one inside payload, does not change the framing, and `locked_o` stays 1 until reset.
- R5: After lock, each packet starts with a 50-bit header sent MSB first. Its fields are channel = bits [49:45], word count = bits [44:35] and tag = bits [34:0].
- R6: A header equal to the sync pattern is a sync packet with no payload. It produces no output word.
- R7: A header that is not the sync pattern and has a word count of 0 is an empty packet with no payload. It produces no output word.
- R8: Payload words are 10 bits, sent MSB first. Each word appears on `word_o` with `word_vld_o` high for one cycle, one clock edge after the edge that captured its last bit pair. `word_first_o` marks word 1 and `word_last_o` marks the word that ends the count, so a count of 1 raises both.
- R9: The header outputs take the fields of a data packet when its header is accepted. They stay unchanged through all words of that packet, up to the maximum count of 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, one bit pair per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_i | input | LANES (2) | Captured bit pair; bit 1 is the earlier bit |
| word_o | output | WORD_W (10) | Payload word |
| word_vld_o | output | 1 | One-cycle strobe marking a valid payload word |
| word_first_o | output | 1 | Marks the first word of a packet |
| word_last_o | output | 1 | Marks the word that ends the packet's count |
| hdr_chan_o | output | CHAN_W (5) | Channel field of the current data packet |
| hdr_count_o | output | CNT_W (10) | Word count of the current data packet |
| hdr_tag_o | output | HDR_W-CHAN_W-CNT_W (35) | Tag field of the current data packet |
| locked_o | output | 1 | High once word alignment has been fixed |

## Verification
The bench locks the block once at an odd bit phase and once at an even one. A deframer that compared only one window offset would never lock in one of the two runs, and one that used the wrong phase would produce shifted words. It puts a copy of the sync pattern inside a payload at an offset that differs from the locked phase. A design that re-aligned on every match would corrupt that packet and all packets after it. It sends data-shaped bits before lock, a sync packet and an empty packet after lock, a one-word packet and a 1023-word packet. A block that leaked unlocked or filtered packets would show unexpected words, and a block with an off-by-one count would misplace the last marker or lose the framing.

// File: rtl/deframer_pkg.sv
// Shared types for the serial link deframer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package deframer_pkg;

    // Packet parser phase: collecting a header or collecting payload words
    typedef enum logic {
        ST_HDR = 1'b0,
        ST_PAY = 1'b1
    } parse_state_e;

endpackage

// File: rtl/header_decode.sv
// Splits a complete packet header into its fields and classifies it.
// Assumes: header is MSB-first; channel on top, word count below it, tag
// in the remaining low bits. The sync check takes priority over the empty check.
module header_decode #(
    parameter int              HDR_W     = 50,
    parameter int              CHAN_W    = 5,
    parameter int              CNT_W     = 10,
    parameter logic [HDR_W-1:0] SYNC_WORD = 50'h2_B5C3_9E16_0F4D
) (
    input  logic [HDR_W-1:0]              hdr_i,
    output logic                          is_sync_o,
    output logic                          is_empty_o,
    output logic [CHAN_W-1:0]             chan_o,
    output logic [CNT_W-1:0]              count_o,
    output logic [HDR_W-CHAN_W-CNT_W-1:0] tag_o
);

    assign chan_o  = hdr_i[HDR_W-1 -: CHAN_W];
    assign count_o = hdr_i[HDR_W-CHAN_W-1 -: CNT_W];
    assign tag_o   = hdr_i[HDR_W-CHAN_W-CNT_W-1:0];

    assign is_sync_o  = (hdr_i == SYNC_WORD);
    assign is_empty_o = !is_sync_o && (count_o == '0);

endmodule

// File: rtl/sync_hunter.sv
// Looks for the sync pattern at every bit offset of a sliding window.
// On the first hit it fixes the bit phase once and then delivers aligned
// bit groups to the parser.
// Assumes: pair_i[LANES-1] is the earliest bit; HDR_W is a multiple of LANES.
module sync_hunter #(
    parameter int              LANES     = 2,
    parameter int              HDR_W     = 50,
    parameter logic [HDR_W-1:0] SYNC_WORD = 50'h2_B5C3_9E16_0F4D,
    parameter int              PH_W      = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] pair_i,
    output logic             locked_o,
    output logic [PH_W-1:0]  phase_o,
    output logic             beat_vld_o,
    output logic [LANES-1:0] beat_o
);

    localparam int SR_W = HDR_W + LANES - 1;

    logic [SR_W-1:0]  sr_q;
    logic [LANES-1:0] hit;
    logic             hit_any;
    logic [PH_W-1:0]  hit_off;
    logic             locked_q;
    logic [PH_W-1:0]  phase_q;
    logic [PH_W-1:0]  phase_use;

    // Purpose: slide the newest bit group into the window, newest at bit 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= {sr_q[SR_W-LANES-1:0], pair_i};
        end
    end

    // One comparator per bit offset of the window
    for (genvar k = 0; k < LANES; k++) begin : g_cmp
        assign hit[k] = (sr_q[k+HDR_W-1 -: HDR_W] == SYNC_WORD);
    end

    // Purpose: pick the lowest matching offset
    always_comb begin
        hit_any = |hit;
        hit_off = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (hit[k]) begin
                hit_off = PH_W'(k);
            end
        end
    end

    // Purpose: record lock and phase on the first match only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            phase_q  <= '0;
        end else if (!locked_q && hit_any) begin
            locked_q <= 1'b1;
            phase_q  <= hit_off;
        end
    end

    assign phase_use  = locked_q ? phase_q : hit_off;
    assign beat_vld_o = locked_q || hit_any;
    assign locked_o   = locked_q;
    assign phase_o    = phase_q;

    // Phase selection: a single-lane link needs none
    if (LANES == 1) begin : g_one_lane
        assign beat_o = pair_i;
    end else begin : g_multi_lane
        logic [2*LANES-2:0] ext;
        assign ext    = {sr_q[LANES-2:0], pair_i};
        assign beat_o = ext[phase_use +: LANES];
    end

endmodule

// File: rtl/packet_parser.sv
// Cuts the aligned stream into header and payload, drops sync and empty
// packets, and emits payload words with first/last markers.
// Assumes: beat_i arrives only while beat_vld_i is high and starts at a
// packet boundary; HDR_W and WORD_W are multiples of LANES, WORD_W >= 2*LANES.
module packet_parser
    import deframer_pkg::*;
#(
    parameter int              LANES     = 2,
    parameter int              HDR_W     = 50,
    parameter int              WORD_W    = 10,
    parameter int              CHAN_W    = 5,
    parameter int              CNT_W     = 10,
    parameter logic [HDR_W-1:0] SYNC_WORD = 50'h2_B5C3_9E16_0F4D
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          beat_vld_i,
    input  logic [LANES-1:0]              beat_i,
    output logic [WORD_W-1:0]             word_o,
    output logic                          word_vld_o,
    output logic                          word_first_o,
    output logic                          word_last_o,
    output logic [CHAN_W-1:0]             hdr_chan_o,
    output logic [CNT_W-1:0]              hdr_count_o,
    output logic [HDR_W-CHAN_W-CNT_W-1:0] hdr_tag_o
);

    localparam int HDR_BEATS  = HDR_W / LANES;
    localparam int WORD_BEATS = WORD_W / LANES;
    localparam int ACC_W      = HDR_W - LANES;
    localparam int BC_W       = $clog2(HDR_BEATS + 1);
    localparam int TAG_W      = HDR_W - CHAN_W - CNT_W;

    parse_state_e      state_q;
    logic [BC_W-1:0]   beat_cnt_q;
    logic [ACC_W-1:0]  acc_q;
    logic [CNT_W-1:0]  left_q;
    logic              first_pend_q;

    logic [HDR_W-1:0]  hdr_full;
    logic [WORD_W-1:0] word_full;
    logic              hdr_done;
    logic              word_done;
    logic              dec_sync;
    logic              dec_empty;
    logic [CHAN_W-1:0] dec_chan;
    logic [CNT_W-1:0]  dec_count;
    logic [TAG_W-1:0]  dec_tag;
    logic              take_hdr;

    assign hdr_full  = {acc_q, beat_i};
    assign word_full = {acc_q[WORD_W-LANES-1:0], beat_i};
    assign hdr_done  = beat_vld_i && (state_q == ST_HDR) && (beat_cnt_q == BC_W'(HDR_BEATS - 1));
    assign word_done = beat_vld_i && (state_q == ST_PAY) && (beat_cnt_q == BC_W'(WORD_BEATS - 1));
    assign take_hdr  = hdr_done && !dec_sync && !dec_empty;

    header_decode #(
        .HDR_W     (HDR_W),
        .CHAN_W    (CHAN_W),
        .CNT_W     (CNT_W),
        .SYNC_WORD (SYNC_WORD)
    ) u_dec (
        .hdr_i      (hdr_full),
        .is_sync_o  (dec_sync),
        .is_empty_o (dec_empty),
        .chan_o     (dec_chan),
        .count_o    (dec_count),
        .tag_o      (dec_tag)
    );

    // Purpose: shift aligned bits into the shared header/word accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (beat_vld_i) begin
            acc_q <= {acc_q[ACC_W-LANES-1:0], beat_i};
        end
    end

    // Purpose: count bit groups within the current header or word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt_q <= '0;
        end else if (beat_vld_i) begin
            if (hdr_done || word_done) begin
                beat_cnt_q <= '0;
            end else begin
                beat_cnt_q <= beat_cnt_q + BC_W'(1);
            end
        end
    end

    // Purpose: step between header and payload, tracking words still owed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_HDR;
            left_q       <= '0;
            first_pend_q <= 1'b0;
        end else if (take_hdr) begin
            state_q      <= ST_PAY;
            left_q       <= dec_count;
            first_pend_q <= 1'b1;
        end else if (word_done) begin
            left_q       <= left_q - CNT_W'(1);
            first_pend_q <= 1'b0;
            if (left_q == CNT_W'(1)) begin
                state_q <= ST_HDR;
            end
        end
    end

    // Purpose: register each finished payload word and its markers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o       <= '0;
            word_vld_o   <= 1'b0;
            word_first_o <= 1'b0;
            word_last_o  <= 1'b0;
        end else begin
            word_vld_o   <= word_done;
            word_first_o <= word_done && first_pend_q;
            word_last_o  <= word_done && (left_q == CNT_W'(1));
            if (word_done) begin
                word_o <= word_full;
            end
        end
    end

    // Purpose: hold the fields of the accepted data header for its words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_chan_o  <= '0;
            hdr_count_o <= '0;
            hdr_tag_o   <= '0;
        end else if (take_hdr) begin
            hdr_chan_o  <= dec_chan;
            hdr_count_o <= dec_count;
            hdr_tag_o   <= dec_tag;
        end
    end

endmodule

// File: rtl/link_deframer.sv
// Top of the serial link deframer: sync hunting and alignment followed by
// packet parsing. Word output is possible only after lock, because the
// parser receives no bits before then.
// Assumes: pair_i comes from double-edge capture flops with the earlier bit
// in the upper position.
module link_deframer #(
    parameter int              LANES     = 2,
    parameter int              HDR_W     = 50,
    parameter int              WORD_W    = 10,
    parameter int              CHAN_W    = 5,
    parameter int              CNT_W     = 10,
    parameter logic [HDR_W-1:0] SYNC_WORD = 50'h2_B5C3_9E16_0F4D
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              pair_i,
    output logic [WORD_W-1:0]             word_o,
    output logic                          word_vld_o,
    output logic                          word_first_o,
    output logic                          word_last_o,
    output logic [CHAN_W-1:0]             hdr_chan_o,
    output logic [CNT_W-1:0]              hdr_count_o,
    output logic [HDR_W-CHAN_W-CNT_W-1:0] hdr_tag_o,
    output logic                          locked_o
);

    localparam int PH_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic             beat_vld;
    logic [LANES-1:0] beat;
    logic [PH_W-1:0]  lock_phase;

    sync_hunter #(
        .LANES     (LANES),
        .HDR_W     (HDR_W),
        .SYNC_WORD (SYNC_WORD),
        .PH_W      (PH_W)
    ) u_hunt (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_i     (pair_i),
        .locked_o   (locked_o),
        .phase_o    (lock_phase),
        .beat_vld_o (beat_vld),
        .beat_o     (beat)
    );

    packet_parser #(
        .LANES     (LANES),
        .HDR_W     (HDR_W),
        .WORD_W    (WORD_W),
        .CHAN_W    (CHAN_W),
        .CNT_W     (CNT_W),
        .SYNC_WORD (SYNC_WORD)
    ) u_parse (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat_vld_i   (beat_vld),
        .beat_i       (beat),
        .word_o       (word_o),
        .word_vld_o   (word_vld_o),
        .word_first_o (word_first_o),
        .word_last_o  (word_last_o),
        .hdr_chan_o   (hdr_chan_o),
        .hdr_count_o  (hdr_count_o),
        .hdr_tag_o    (hdr_tag_o)
    );

endmodule

// File: rtl/deframer_checker.sv
// Protocol properties of the deframer outputs, attached by bind.
// Assumes: sampled on the rising clock edge; rst_n is synchronous active-low.
module deframer_checker #(
    parameter int PH_W   = 1,
    parameter int CHAN_W = 5,
    parameter int CNT_W  = 10,
    parameter int TAG_W  = 35
) (
    input logic              clk,
    input logic              rst_n,
    input logic              locked_o,
    input logic [PH_W-1:0]   lock_phase,
    input logic              word_vld_o,
    input logic              word_first_o,
    input logic              word_last_o,
    input logic [CHAN_W-1:0] hdr_chan_o,
    input logic [CNT_W-1:0]  hdr_count_o,
    input logic [TAG_W-1:0]  hdr_tag_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!locked_o && !word_vld_o)); // R1
    AST_NO_WORD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n) !locked_o |-> !word_vld_o); // R2
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) locked_o |=> locked_o); // R4
    AST_PHASE_FIXED: assert property (@(posedge clk) disable iff (!rst_n) locked_o |=> $stable(lock_phase)); // R4
    AST_NONEMPTY_ONLY: assert property (@(posedge clk) disable iff (!rst_n) word_vld_o |-> (hdr_count_o != '0)); // R7
    AST_MARKS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n) (word_first_o || word_last_o) |-> word_vld_o); // R8
    AST_WORD_SPACING: assert property (@(posedge clk) disable iff (!rst_n) word_vld_o |=> !word_vld_o); // R8
    AST_HDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (word_vld_o && !word_first_o) |-> ($stable(hdr_chan_o) && $stable(hdr_count_o) && $stable(hdr_tag_o))); // R9

endmodule

bind link_deframer deframer_checker #(
    .PH_W   (PH_W),
    .CHAN_W (CHAN_W),
    .CNT_W  (CNT_W),
    .TAG_W  (HDR_W - CHAN_W - CNT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .locked_o     (locked_o),
    .lock_phase   (lock_phase),
    .word_vld_o   (word_vld_o),
    .word_first_o (word_first_o),
    .word_last_o  (word_last_o),
    .hdr_chan_o   (hdr_chan_o),
    .hdr_count_o  (hdr_count_o),
    .hdr_tag_o    (hdr_tag_o)
);

// File: tb/link_deframer_tb_top.sv
// Scoreboard bench: stream builders queue bits and expected words, a
// player drives the bits two per cycle, and a monitor compares outputs.
module link_deframer_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [49:0] SYNC       = 50'h2_B5C3_9E16_0F4D;

    typedef struct {
        logic [9:0]  w;
        logic        f;
        logic        l;
        logic [4:0]  ch;
        logic [9:0]  cnt;
        logic [34:0] tag;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pair_i = 2'b00;
    logic [9:0]  word_o;
    logic        word_vld_o;
    logic        word_first_o;
    logic        word_last_o;
    logic [4:0]  hdr_chan_o;
    logic [9:0]  hdr_count_o;
    logic [34:0] hdr_tag_o;
    logic        locked_o;

    bit          bits_q[$];
    exp_t        exp_q[$];
    int          checks = 0;
    int          errors = 0;
    int          words_seen = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #(CLK_PERIOD / 2) clk = ~clk;

    link_deframer #(.SYNC_WORD(SYNC)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pair_i       (pair_i),
        .word_o       (word_o),
        .word_vld_o   (word_vld_o),
        .word_first_o (word_first_o),
        .word_last_o  (word_last_o),
        .hdr_chan_o   (hdr_chan_o),
        .hdr_count_o  (hdr_count_o),
        .hdr_tag_o    (hdr_tag_o),
        .locked_o     (locked_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic push_field(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bits_q.push_back(v[i]);
    endtask

    task automatic push_junk(input int n);
        for (int i = 0; i < n; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            bits_q.push_back(lcg[16]);
        end
    endtask

    // Queues a packet; payload word k is derived from seed; expectations optional
    task automatic push_packet(input logic [4:0] ch, input int n, input logic [34:0] tag,
                               input int seed, input bit expect_it, input string req);
        push_field({ch, n[9:0], tag}, 50);
        for (int k = 0; k < n; k++) begin
            logic [9:0] w;
            exp_t e;
            w = 10'((seed * 37 + k * 113 + (k >> 3)) & 32'h3FF);
            push_field({54'd0, w}, 10);
            if (expect_it) begin
                e.w = w; e.f = (k == 0); e.l = (k == n - 1);
                e.ch = ch; e.cnt = n[9:0]; e.tag = tag; e.req = req;
                exp_q.push_back(e);
            end
        end
    endtask

    // Six-word packet whose payload carries the sync pattern at bit offset 1
    task automatic push_embedded_sync();
        logic [59:0] pv;
        pv = {1'b0, SYNC, 9'h0A5};
        push_field({5'd9, 10'd6, 35'h0_1234_5678}, 50);
        push_field({4'd0, pv}, 60);
        for (int i = 0; i < 6; i++) begin
            exp_t e;
            e.w = pv[59 - 10 * i -: 10]; e.f = (i == 0); e.l = (i == 5);
            e.ch = 5'd9; e.cnt = 10'd6; e.tag = 35'h0_1234_5678; e.req = "R4";
            exp_q.push_back(e);
        end
    endtask

    // Plays all queued bits, earlier bit in pair_i[1], then pads with zeros
    task automatic play();
        while (bits_q.size() > 0) begin
            bit b1, b0;
            b1 = bits_q.pop_front();
            b0 = (bits_q.size() > 0) ? bits_q.pop_front() : 1'b0;
            @(negedge clk);
            pair_i = {b1, b0};
        end
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            pair_i = 2'b00;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pair_i = 2'b00;
        repeat (3) @(negedge clk);
        chk(locked_o == 1'b0, "R1", "locked_o in reset", locked_o, 0);
        chk(word_vld_o == 1'b0, "R1", "word_vld_o in reset", word_vld_o, 0);
        rst_n = 1'b1;
    endtask

    // Monitor: compare each produced word against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && word_vld_o) begin
            words_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 R6 R7", "unexpected word", word_o, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(word_o == e.w, e.req, "word", word_o, e.w);
                chk(word_first_o == e.f && word_last_o == e.l, e.req, "first/last",
                    {word_first_o, word_last_o}, {e.f, e.l});
                chk(hdr_chan_o == e.ch && hdr_count_o == e.cnt && hdr_tag_o == e.tag, e.req,
                    "header fields", {hdr_chan_o, hdr_count_o, hdr_tag_o}, {e.ch, e.cnt, e.tag});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 0, 1);
        finish_sim();
    end

    initial begin
        // Run A: no sync at all, data-shaped bits must not leak (R2)
        do_reset();
        push_junk(120);
        push_packet(5'd3, 2, 35'h5_0000_0001, 1, 1'b0, "R2");
        push_junk(30);
        play();
        chk(locked_o == 1'b0, "R2", "locked_o without sync", locked_o, 0);
        chk(words_seen == 0, "R2", "words before lock", words_seen, 0);

        // Run B: odd phase lock, filtering, embedded sync, max count
        do_reset();
        push_junk(37);
        push_packet(5'd4, 3, 35'h0_0000_00AA, 2, 1'b0, "R2");
        push_field({14'd0, SYNC}, 50);
        push_packet(5'd1, 1, 35'h7_0000_0011, 3, 1'b1, "R8");
        push_field({5'd2, 10'd0, 35'h1_2345_6789}, 50);
        push_packet(5'd17, 3, 35'h2_2222_2222, 4, 1'b1, "R7");
        push_field({14'd0, SYNC}, 50);
        push_packet(5'd30, 2, 35'h3_3333_3333, 5, 1'b1, "R6");
        push_embedded_sync();
        push_packet(5'd6, 4, 35'h4_4444_4444, 6, 1'b1, "R5");
        push_packet(5'd31, 1023, 35'h7_FFFF_FFFF, 7, 1'b1, "R9");
        push_packet(5'd0, 2, 35'h0_0000_0001, 8, 1'b1, "R4");
        play();
        chk(locked_o == 1'b1, "R3", "locked_o after odd-phase sync", locked_o, 1);
        chk(exp_q.size() == 0, "R8", "words still owed", exp_q.size(), 0);
        chk(words_seen == 1 + 3 + 2 + 6 + 4 + 1023 + 2, "R6", "word total", words_seen, 1041);

        // Run C: reset drops lock, then even phase lock
        do_reset();
        words_seen = 0;
        push_junk(40);
        push_field({14'd0, SYNC}, 50);
        push_packet(5'd12, 4, 35'h6_0606_0606, 9, 1'b1, "R3");
        push_packet(5'd13, 2, 35'h1_0101_0101, 10, 1'b1, "R5");
        play();
        chk(locked_o == 1'b1, "R3", "locked_o after even-phase sync", locked_o, 1);
        chk(exp_q.size() == 0, "R8", "words still owed", exp_q.size(), 0);
        chk(words_seen == 6, "R7", "word total", words_seen, 6);
        finish_sim();
    end

endmodule